// File: doc/BRIEF.md
# Access-Protection Register Page

This block is the sixteen-byte register page that governs who may read or write the memory blocks of a dual-port storage device. A serial host reads and writes the page one byte at a time through an address, write-data and write-strobe port, and every read returns the addressed byte combinationally. The page's contents drive field outputs that the rest of the device decodes. These outputs are the serial and RFID access codes and the tamper-override bit for each of the eight memory blocks, the page-level write-protect mask for block 0, the access code that guards the upper part of the page, and the tamper flag.

Each per-block control byte carries a volatile lock flag. The flag is set again whenever power-good drops or the block is reset. Once software clears the flag, the byte cannot be changed until that happens. The tamper flag can be raised only by a request from the RFID side and lowered only by a serial write. The block also has a coil-detect enable bit and the matching status bit, which follows a coil-present input while detection is enabled. The synchronous reset stands for power-up. At reset the nonvolatile fields read all ones and the tamper flag reads zero.

Top module: `pp_regfile`

## Requirements
- R1: After reset, every per-block field, the upper-page access code, the block-0 mask and every reserved byte read as ones. All lock flags read 1, and the tamper flag and detect-enable read 0. Byte 10 therefore reads 0xFC.
- R2: Bytes 0 to 7 are the control bytes of blocks 0 to 7. Each one holds the serial access code at bits [1:0], the RFID access code at [3:2], the tamper-override bit at bit 4 and the lock flag at bit 7. Bits 6:5 read 1, and the fields appear on blk_pb, blk_rf and blk_tw at the slice of that block.
- R3: While the lock flag of a control byte is 0, a write to that byte changes nothing in it.
- R4: A write to an unlocked control byte loads wdata[7] into the lock flag. A write with bit 7 set never raises a cleared flag, and reading has no side effect.
- R5: While pwr_good is low, all lock flags, including the upper-page lock, return to 1 and detect-enable returns to 0. Serial writes are ignored, and the nonvolatile fields keep their values.
- R6: Byte 8 holds the upper-page access code at bits [1:0] and its own lock flag at bit 7, with bits 6:2 reading 1. The code and the flag change only while that lock flag is 1, and the flag can only be cleared.
- R7: Bytes 9 to 15 accept writes only while the upper-page access code equals 2'b11.
- R8: Byte 9 is the block-0 page write-protect mask on page_wp. Bit n belongs to page n of block 0.
- R9: Bit 0 of byte 10 is the tamper flag. A serial write of 0 clears it and a serial write of 1 is ignored. A tamper_set pulse sets it, and a set wins over a serial clear in the same cycle.
- R10: Bit 1 of byte 10 is detect-enable. It is writable, and it stays set for any number of cycles until it is written to 0, power-good drops or reset is applied.
- R11: Bit 2 of byte 10 reads 1 while detect-enable is 0 and follows coil_present while detect-enable is 1.
- R12: Byte 14 always reads 0xFF and ignores writes. Bytes 11, 12, 13 and 15 are plain storage under the rule of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| pwr_good | input | 1 | Power-good; low forces the volatile bits and blocks writes |
| wr_en | input | 1 | Serial byte write strobe |
| addr | input | 4 | Byte address within the page |
| wdata | input | 8 | Serial write data |
| rdata | output | 8 | Byte at addr, combinational |
| tamper_set | input | 1 | RFID-side request to set the tamper flag |
| coil_present | input | 1 | Coil sense result |
| blk_pb | output | 16 | Serial access code per block, 2 bits each |
| blk_rf | output | 16 | RFID access code per block, 2 bits each |
| blk_tw | output | 8 | Tamper-override bit per block |
| page_wp | output | 8 | Block-0 page write-protect mask |
| pb_ap | output | 2 | Upper-page access code |
| tamper | output | 1 | Tamper flag |

## Verification
Two cases can fall in the same cycle. In the first, an RFID tamper request arrives together with a serial write of 0 to the tamper bit. In the second, a serial write arrives while power-good is low. Directed steps drive the tamper request and the clearing write on the same clock, and the flag is expected to stay 1. Other steps place a write to a locked or unlocked byte in a cycle where power-good is low, and that write is expected to vanish while the lock flags re-arm. A random phase then mixes these events freely, and a behavioural model in the bench judges every output and the addressed read byte on every clock.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int NBLK       = 8;
    localparam int PAGE_BYTES = 16;
    localparam int DW         = 8;
    localparam int AW         = $clog2(PAGE_BYTES);
    localparam int BW         = $clog2(NBLK);

    localparam int APCTL_ADDR = NBLK;
    localparam int PGWP_ADDR  = NBLK + 1;
    localparam int TAMP_ADDR  = NBLK + 2;
    localparam int RES_BASE   = NBLK + 3;
    localparam int LOCK_ADDR  = 14;
    localparam int RES_NUM    = PAGE_BYTES - RES_BASE;
    localparam int RW         = $clog2(RES_NUM);

    typedef enum logic [1:0] {
        ACC_OFF_A  = 2'b00,
        ACC_OFF_B  = 2'b01,
        ACC_RDONLY = 2'b10,
        ACC_FULL   = 2'b11
    } acc_e;

    typedef struct packed {
        logic tw;
        acc_e rf;
        acc_e pb;
    } blk_ctl_t;

    localparam blk_ctl_t CTL_INIT = '{tw: 1'b1, rf: ACC_FULL, pb: ACC_FULL};

    function automatic logic [DW-1:0] ctl_byte(input logic lk, input blk_ctl_t c);
        return {lk, 2'b11, c};
    endfunction

    function automatic logic [DW-1:0] apctl_byte(input logic lk, input acc_e code);
        return {lk, 5'b11111, code};
    endfunction

    function automatic logic [DW-1:0] tamp_byte(input logic dc, input logic de, input logic t);
        return {5'b11111, dc, de, t};
    endfunction

endpackage

// File: rtl/pp_blk_ctl.sv
module pp_blk_ctl
    import pp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_good,
    input  logic     wr_hit,
    input  logic     wd_lock,
    input  blk_ctl_t wd_ctl,
    output blk_ctl_t ctl,
    output logic     lock_ok
);

    blk_ctl_t ctl_q;
    logic     lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_INIT;
            lock_q <= 1'b1;
        end else if (!pwr_good) begin
            lock_q <= 1'b1;
        end else if (wr_hit && lock_q) begin
            ctl_q  <= wd_ctl;
            lock_q <= wd_lock;
        end
    end

    assign ctl     = ctl_q;
    assign lock_ok = lock_q;

    // R3
    locked_fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_q |=> $stable(ctl_q));

    // R4
    lock_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!lock_q && pwr_good) |=> !lock_q);

    // R5
    lock_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> lock_q);

endmodule

// File: rtl/pp_ap_regs.sv
module pp_ap_regs
    import pp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pwr_good,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output acc_e                        pb_ap,
    output logic                        ap_lock,
    output logic [DW-1:0]               page_wp,
    output logic [RES_NUM-1:0][DW-1:0]  res_rd,
    output logic                        hi_wr_ok
);

    acc_e          pb_ap_q;
    logic          ap_lock_q;
    logic [DW-1:0] page_wp_q;

    assign hi_wr_ok = pwr_good && wr_en && (pb_ap_q == ACC_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            pb_ap_q   <= ACC_FULL;
            ap_lock_q <= 1'b1;
        end else if (!pwr_good) begin
            ap_lock_q <= 1'b1;
        end else if (wr_en && addr == AW'(APCTL_ADDR) && ap_lock_q) begin
            pb_ap_q   <= acc_e'(wdata[1:0]);
            ap_lock_q <= wdata[DW-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_wp_q <= '1;
        end else if (hi_wr_ok && addr == AW'(PGWP_ADDR)) begin
            page_wp_q <= wdata;
        end
    end

    for (genvar k = 0; k < RES_NUM; k++) begin : g_res
        if (RES_BASE + k == LOCK_ADDR) begin : g_fixed
            assign res_rd[k] = '1;
        end else begin : g_store
            logic [DW-1:0] res_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '1;
                end else if (hi_wr_ok && addr == AW'(RES_BASE + k)) begin
                    res_q <= wdata;
                end
            end
            assign res_rd[k] = res_q;
        end
    end

    assign pb_ap   = pb_ap_q;
    assign ap_lock = ap_lock_q;
    assign page_wp = page_wp_q;

    // R6
    pb_ap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ap_lock_q |=> $stable(pb_ap_q));

    // R7
    page_wp_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (pb_ap_q != ACC_FULL) |=> $stable(page_wp_q));

endmodule

// File: rtl/pp_tamper_coil.sv
module pp_tamper_coil (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic       wr_hit,
    input  logic [1:0] wd,
    input  logic       tamper_set,
    input  logic       coil_present,
    output logic       tamper,
    output logic       det_en,
    output logic       det_coil
);

    logic tamper_q;
    logic de_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tamper_q <= 1'b0;
        end else if (tamper_set) begin
            tamper_q <= 1'b1;
        end else if (wr_hit && !wd[0]) begin
            tamper_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            de_q <= 1'b0;
        end else if (wr_hit) begin
            de_q <= wd[1];
        end
    end

    assign tamper   = tamper_q;
    assign det_en   = de_q;
    assign det_coil = de_q ? coil_present : 1'b1;

    // R9
    tamper_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        tamper_set |=> tamper_q);

    // R9
    tamper_no_serial_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!tamper_q && !tamper_set) |=> !tamper_q);

    // R10
    det_en_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> !de_q);

endmodule

// File: rtl/pp_regfile.sv
module pp_regfile
    import pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_good,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 tamper_set,
    input  logic                 coil_present,
    output logic [2*NBLK-1:0]    blk_pb,
    output logic [2*NBLK-1:0]    blk_rf,
    output logic [NBLK-1:0]      blk_tw,
    output logic [DW-1:0]        page_wp,
    output logic [1:0]           pb_ap,
    output logic                 tamper
);

    blk_ctl_t                   ctl_a [NBLK];
    logic [NBLK-1:0]            lock_a;
    acc_e                       pb_ap_e;
    logic                       ap_lock;
    logic [RES_NUM-1:0][DW-1:0] res_rd;
    logic                       hi_wr_ok;
    logic                       det_en;
    logic                       det_coil;
    logic [RW-1:0]              res_idx;

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        pp_blk_ctl u_ctl (
            .clk      (clk),
            .rst      (rst),
            .pwr_good (pwr_good),
            .wr_hit   (wr_en && addr == AW'(i)),
            .wd_lock  (wdata[DW-1]),
            .wd_ctl   (blk_ctl_t'(wdata[$bits(blk_ctl_t)-1:0])),
            .ctl      (ctl_a[i]),
            .lock_ok  (lock_a[i])
        );
        assign blk_pb[2*i +: 2] = ctl_a[i].pb;
        assign blk_rf[2*i +: 2] = ctl_a[i].rf;
        assign blk_tw[i]        = ctl_a[i].tw;
    end

    pp_ap_regs u_ap (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .pb_ap    (pb_ap_e),
        .ap_lock  (ap_lock),
        .page_wp  (page_wp),
        .res_rd   (res_rd),
        .hi_wr_ok (hi_wr_ok)
    );

    pp_tamper_coil u_tc (
        .clk          (clk),
        .rst          (rst),
        .pwr_good     (pwr_good),
        .wr_hit       (hi_wr_ok && addr == AW'(TAMP_ADDR)),
        .wd           (wdata[1:0]),
        .tamper_set   (tamper_set),
        .coil_present (coil_present),
        .tamper       (tamper),
        .det_en       (det_en),
        .det_coil     (det_coil)
    );

    assign pb_ap   = pb_ap_e;
    assign res_idx = RW'(addr - AW'(RES_BASE));

    always_comb begin
        if (addr < AW'(NBLK)) begin
            rdata = ctl_byte(lock_a[addr[BW-1:0]], ctl_a[addr[BW-1:0]]);
        end else if (addr == AW'(APCTL_ADDR)) begin
            rdata = apctl_byte(ap_lock, pb_ap_e);
        end else if (addr == AW'(PGWP_ADDR)) begin
            rdata = page_wp;
        end else if (addr == AW'(TAMP_ADDR)) begin
            rdata = tamp_byte(det_coil, det_en, tamper);
        end else begin
            rdata = res_rd[res_idx];
        end
    end

    // R12
    fixed_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == AW'(LOCK_ADDR)) |-> (rdata == '1));

endmodule

// File: tb/tb_pp_regfile.sv
`timescale 1ns/1ps
module tb_pp_regfile;

    logic        clk = 1'b0;
    logic        rst, pwr_good, wr_en, tamper_set, coil_present;
    logic [3:0]  addr;
    logic [7:0]  wdata, rdata, page_wp;
    logic [15:0] blk_pb, blk_rf;
    logic [7:0]  blk_tw;
    logic [1:0]  pb_ap;
    logic        tamper;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    int m_pb[8], m_rf[8], m_tw[8], m_lk[8];
    int m_aplk, m_pbap, m_wp, m_tamp, m_de;
    int m_res[16];

    always #2.5 clk = ~clk;

    pp_regfile dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .tamper_set(tamper_set), .coil_present(coil_present),
        .blk_pb(blk_pb), .blk_rf(blk_rf), .blk_tw(blk_tw),
        .page_wp(page_wp), .pb_ap(pb_ap), .tamper(tamper)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_init();
        for (int i = 0; i < 8; i++) begin
            m_pb[i] = 3; m_rf[i] = 3; m_tw[i] = 1; m_lk[i] = 1;
        end
        m_aplk = 1; m_pbap = 3; m_wp = 255; m_tamp = 0; m_de = 0;
        for (int i = 0; i < 16; i++) m_res[i] = 255;
    endtask

    task automatic model_update();
        int a, d;
        bit hi;
        a = int'(addr);
        d = int'(wdata);
        if (rst) begin
            model_init();
            return;
        end
        hi = pwr_good && wr_en && (m_pbap == 3);
        if (tamper_set) m_tamp = 1;
        else if (hi && a == 10 && (d % 2) == 0) m_tamp = 0;
        if (!pwr_good) begin
            for (int i = 0; i < 8; i++) m_lk[i] = 1;
            m_aplk = 1;
            m_de = 0;
        end else if (wr_en) begin
            if (a < 8) begin
                if (m_lk[a] == 1) begin
                    m_pb[a] = d % 4;
                    m_rf[a] = (d / 4) % 4;
                    m_tw[a] = (d / 16) % 2;
                    m_lk[a] = d / 128;
                end
            end else if (a == 8) begin
                if (m_aplk == 1) begin
                    m_pbap = d % 4;
                    m_aplk = d / 128;
                end
            end else if (hi) begin
                if (a == 9) m_wp = d;
                else if (a == 10) m_de = (d / 2) % 2;
                else if (a != 14) m_res[a] = d;
            end
        end
    endtask

    function automatic int exp_rd(input int a);
        int dc;
        if (a < 8) return m_lk[a] * 128 + 96 + m_tw[a] * 16 + m_rf[a] * 4 + m_pb[a];
        if (a == 8) return m_aplk * 128 + 124 + m_pbap;
        if (a == 9) return m_wp;
        if (a == 10) begin
            dc = (m_de == 1) ? int'(coil_present) : 1;
            return 248 + dc * 4 + m_de * 2 + m_tamp;
        end
        if (a == 14) return 255;
        return m_res[a];
    endfunction

    function automatic string rd_tag(input int a);
        if (a < 8) return "R2";
        if (a == 8) return "R6";
        if (a == 9) return "R8";
        if (a == 10) return "R9";
        return "R12";
    endfunction

    task automatic compare_all();
        for (int i = 0; i < 8; i++) begin
            chk("R2 pb", int'(blk_pb[2*i +: 2]), m_pb[i]);
            chk("R2 rf", int'(blk_rf[2*i +: 2]), m_rf[i]);
            chk("R2 tw", int'(blk_tw[i]), m_tw[i]);
        end
        chk("R6 pb_ap", int'(pb_ap), m_pbap);
        chk("R8 page_wp", int'(page_wp), m_wp);
        chk("R9 tamper", int'(tamper), m_tamp);
        chk(rd_tag(int'(addr)), int'(rdata), exp_rd(int'(addr)));
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic drive(input bit w, input int a, input int d, input bit ts,
                         input bit pg, input bit coil);
        wr_en = w; addr = 4'(a); wdata = 8'(d);
        tamper_set = ts; pwr_good = pg; coil_present = coil;
        tick();
    endtask

    initial begin
        rst = 1'b1; pwr_good = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
        tamper_set = 1'b0; coil_present = 1'b0;
        model_init();
        tick();
        tick();
        rst = 1'b0;

        // R1 reset state
        drive(0, 0, 0, 0, 1, 0);  chk("R1", int'(rdata), 'hFF);
        drive(0, 8, 0, 0, 1, 0);  chk("R1", int'(rdata), 'hFF);
        drive(0, 10, 0, 0, 1, 0); chk("R1", int'(rdata), 'hFC);
        chk("R1", int'(tamper), 0);
        chk("R1", int'(page_wp), 'hFF);

        // R2 layout
        drive(1, 3, 'h99, 0, 1, 0);
        chk("R2", int'(rdata), 'hF9);
        chk("R2", int'(blk_pb[7:6]), 1);
        chk("R2", int'(blk_rf[7:6]), 2);
        chk("R2", int'(blk_tw[3]), 1);
        // R4 clear lock, R3 locked byte ignores write
        drive(1, 3, 'h1A, 0, 1, 0); chk("R4", int'(rdata), 'h7A);
        drive(1, 3, 'hFF, 0, 1, 0); chk("R3", int'(rdata), 'h7A);
        drive(0, 3, 0, 0, 1, 0);    chk("R4", int'(rdata), 'h7A);
        // R5 write while power-good low is dropped, lock re-armed
        drive(1, 3, 'h80, 0, 0, 0);
        drive(0, 3, 0, 0, 1, 0);    chk("R5", int'(rdata), 'hFA);

        // R6 upper-page lock
        drive(1, 8, 'h02, 0, 1, 0); chk("R6", int'(rdata), 'h7E);
        drive(1, 8, 'hFF, 0, 1, 0); chk("R6", int'(rdata), 'h7E);
        // R7 guarded write
        drive(1, 9, 'h00, 0, 1, 0); chk("R7", int'(page_wp), 'hFF);
        drive(0, 0, 0, 0, 0, 0);
        drive(1, 8, 'h83, 0, 1, 0); chk("R6", int'(rdata), 'hFF);
        drive(1, 9, 'h5A, 0, 1, 0); chk("R8", int'(page_wp), 'h5A);

        // R9 tamper
        drive(0, 10, 0, 1, 1, 0);   chk("R9", int'(rdata), 'hFD);
        drive(1, 10, 'h01, 0, 1, 0); chk("R9", int'(rdata), 'hFD);
        drive(1, 10, 'h00, 1, 1, 0); chk("R9 collision", int'(tamper), 1);
        drive(1, 10, 'h00, 0, 1, 0); chk("R9", int'(rdata), 'hFC);

        // R10 / R11 coil detect
        drive(1, 10, 'h02, 0, 1, 0); chk("R11", int'(rdata), 'hFA);
        for (int k = 0; k < 40; k++) drive(0, 10, 0, 0, 1, 0);
        chk("R10", int'(rdata), 'hFA);
        drive(0, 10, 0, 0, 1, 1);    chk("R11", int'(rdata), 'hFE);
        drive(1, 10, 'h00, 0, 1, 1); chk("R11", int'(rdata), 'hFC);
        drive(1, 10, 'h02, 0, 1, 1);
        drive(0, 10, 0, 0, 0, 1);    chk("R10", int'(rdata), 'hFC);

        // R12 reserved bytes
        drive(1, 14, 'h00, 0, 1, 0); chk("R12", int'(rdata), 'hFF);
        drive(1, 11, 'h3C, 0, 1, 0); chk("R12", int'(rdata), 'h3C);

        // random mix, model compared every clock
        for (int n = 0; n < 4000; n++) begin
            rst = (($urandom % 600) == 0);
            drive(($urandom % 2) == 0, int'($urandom % 16), int'($urandom % 256),
                  ($urandom % 16) == 0, ($urandom % 40) != 0, ($urandom % 2) == 0);
        end
        rst = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule